// File: doc/BRIEF.md
# Dual Cascadable Interval Timer

This block holds two 16-bit down-counters, A and B. Each counter has its own 16-bit reload latch and an 8-bit control byte. A host programs and inspects the timers one byte at a time, through a 4-bit register address, an 8-bit write bus and a combinational read bus. Timer A counts every clock cycle. Timer B counts either every clock cycle or only the cycles in which timer A has just underflowed, so the two can be chained into a 32-bit-range interval.

When a counter underflows, it reloads from its latch and raises a one-cycle event for the interrupt logic. In one-shot mode the timer then stops by itself. Each timer can also drive a port line, either as a one-cycle pulse or as a level that toggles. Start, stop and force-load take effect with fixed, documented cycle offsets, so software can compute exact intervals.

Top module: `dualTimer`

## Requirements
- R1: After reset both counters and both latches hold 0xFFFF, both control bytes read 0x00, both timers are stopped, and `timerUnder` and `portEn` are low.
- R2: Writing a latch byte changes only the latch. The latch low/high bytes are at addresses 0/1 for timer A and 2/3 for timer B. Writing the high byte while that timer is stopped also copies the full latch into the counter. A stopped counter never changes on its own.
- R3: Control bit 0 runs the timer. Timer A's control byte is at address 4 and timer B's at address 5. A write that sets bit 0 from 0 does not change the counter on that edge; each later edge decrements it. An edge that finds the counter at 0 reloads it from the latch instead, and `timerUnder` goes high for the following cycle. The period is therefore latch+1 cycles.
- R4: With control bit 3 set (one-shot), the underflow edge reloads the counter and clears control bit 0. No further underflows follow.
- R5: Control bit 4 is a strobe that copies the latch into the counter on the write edge. It always reads back as 0.
- R6: A write that starts the timer with bit 4 also set loads the latch and holds that value for one extra edge before the first decrement.
- R7: A write that clears bit 0 of a running timer without bit 4 decrements the counter once more on that edge if it is nonzero. After that the counter holds.
- R8: With timer B control bits 6:5 = 10, timer B decrements or reloads only on edges where timer A's underflow pulse is high.
- R9: With timer B control bit 5 set, timer B never counts while running.
- R10: Control bit 1 sets `portEn` for that timer; index 0 is timer A (port line 6) and index 1 is timer B (port line 7). With bit 2 clear, `portVal` equals the underflow pulse. With bit 2 set, `portVal` is a level that becomes 1 when bit 0 rises and inverts on every underflow.
- R11: Reading the counter at addresses 0/1 (A) or 2/3 (B), or reading a control byte, has no side effect. A latch write to a running timer does not disturb the counting; the new value is used from the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| regAddr | input | 4 | Register address |
| wrEn | input | 1 | Write strobe, sampled at the rising edge |
| rdEn | input | 1 | Read enable; `rdData` is 0 when low |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational from `regAddr` |
| timerUnder | output | 2 | One-cycle underflow events, index 0 = A, 1 = B |
| portVal | output | 2 | Port line values for lines 6 (A) and 7 (B) |
| portEn | output | 2 | Port line overrides enabled |

## Verification
A corrupted counter shows on the next read of that counter's address. A wrong reload or a missed hold shows as a shifted underflow pulse within one period, that is latch+1 cycles. A run bit that stays wrong shows in the control byte readback on the cycle after the underflow edge, and as a counter that keeps moving. Errors in the cascade gate and the toggle appear at timer B's count and at `portVal` on the first timer A underflow after the bad state, so the bench compares counter, pulse and port values cycle by cycle against closed-form sequences.

// File: rtl/timerPkg.sv
package timerPkg;
  localparam int BUS_W      = 8;
  localparam int CNT_W      = 2 * BUS_W;
  localparam int ADDR_W     = 4;
  localparam int NUM_TIMERS = 2;
  // control byte of timer t sits at CTRL_BASE + t; latch bytes at 2t, 2t+1
  localparam int CTRL_BASE  = 2 * NUM_TIMERS;

  localparam int BIT_RUN     = 0;
  localparam int BIT_PORT    = 1;
  localparam int BIT_TOGGLE  = 2;
  localparam int BIT_ONESHOT = 3;
  localparam int BIT_LOAD    = 4;
  localparam int BIT_PIN     = 5;
  localparam int BIT_CASCADE = 6;

  // strobes from the register block to one counter datapath
  typedef struct packed {
    logic             latchLoWr;
    logic             latchHiWr;
    logic             ctrlWr;
    logic             forceLoad;
    logic             startNow;
    logic             stopNow;
    logic             runBit;
    logic             countEn;
    logic             oneShot;
    logic             toggleSel;
    logic             portOn;
    logic [BUS_W-1:0] data;
  } timerCmd_t;
endpackage

// File: rtl/timerRegs.sv
module timerRegs
  import timerPkg::*;
(
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [ADDR_W-1:0]                   regAddr,
  input  logic                                wrEn,
  input  logic                                rdEn,
  input  logic [BUS_W-1:0]                    wrData,
  input  logic [NUM_TIMERS-1:0][CNT_W-1:0]    countVal,
  input  logic [NUM_TIMERS-1:0]               expired,
  input  logic [NUM_TIMERS-2:0]               chainPulse,
  output timerCmd_t [NUM_TIMERS-1:0]          cmd,
  output logic [BUS_W-1:0]                    rdData
);
  logic [NUM_TIMERS-1:0][BUS_W-1:0] ctrlView;

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : gTimer
    logic [BUS_W-1:0] ctrlQ;
    logic [BUS_W-1:0] ctrlNext;
    logic             ctrlHit;
    logic             countEn;

    assign ctrlHit = wrEn && (regAddr == ADDR_W'(CTRL_BASE + t));

    always_comb begin
      ctrlNext = ctrlQ;
      if (ctrlHit) begin
        ctrlNext           = wrData;
        ctrlNext[BIT_LOAD] = 1'b0;
      end
      if (expired[t]) ctrlNext[BIT_RUN] = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) ctrlQ <= '0;
      else        ctrlQ <= ctrlNext;
    end

    if (t == 0) begin : gFree
      assign countEn = 1'b1;
    end else begin : gChain
      always_comb begin
        if (ctrlQ[BIT_PIN])          countEn = 1'b0;
        else if (ctrlQ[BIT_CASCADE]) countEn = chainPulse[t-1];
        else                         countEn = 1'b1;
      end
    end

    assign ctrlView[t]       = ctrlQ;
    assign cmd[t].latchLoWr  = wrEn && (regAddr == ADDR_W'(2 * t));
    assign cmd[t].latchHiWr  = wrEn && (regAddr == ADDR_W'(2 * t + 1));
    assign cmd[t].ctrlWr     = ctrlHit;
    assign cmd[t].forceLoad  = ctrlHit && wrData[BIT_LOAD];
    assign cmd[t].startNow   = ctrlHit && wrData[BIT_RUN] && !ctrlQ[BIT_RUN];
    assign cmd[t].stopNow    = ctrlHit && !wrData[BIT_RUN] && ctrlQ[BIT_RUN];
    assign cmd[t].runBit     = ctrlQ[BIT_RUN];
    assign cmd[t].countEn    = countEn;
    assign cmd[t].oneShot    = ctrlQ[BIT_ONESHOT];
    assign cmd[t].toggleSel  = ctrlQ[BIT_TOGGLE];
    assign cmd[t].portOn     = ctrlQ[BIT_PORT];
    assign cmd[t].data       = wrData;
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      for (int t = 0; t < NUM_TIMERS; t++) begin
        if (regAddr == ADDR_W'(2 * t))         rdData = countVal[t][BUS_W-1:0];
        if (regAddr == ADDR_W'(2 * t + 1))     rdData = countVal[t][CNT_W-1:BUS_W];
        if (regAddr == ADDR_W'(CTRL_BASE + t)) rdData = ctrlView[t];
      end
    end
  end
endmodule

// File: rtl/timerCore.sv
module timerCore
  import timerPkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  timerCmd_t        cmd,
  output logic [CNT_W-1:0] count,
  output logic             underQ,
  output logic             expired,
  output logic             portDrive,
  output logic             portEn
);
  logic [CNT_W-1:0] latch;
  logic             holdOne;
  logic             toggleQ;
  logic             writeOverride;
  logic             wrapNow;

  assign writeOverride = cmd.ctrlWr && (cmd.forceLoad || cmd.stopNow);
  assign wrapNow = cmd.runBit && cmd.countEn && !holdOne &&
                   (count == '0) && !writeOverride;
  assign expired   = wrapNow && cmd.oneShot;
  assign portDrive = cmd.toggleSel ? toggleQ : underQ;
  assign portEn    = cmd.portOn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch <= '1;
    end else begin
      if (cmd.latchLoWr) latch[BUS_W-1:0]     <= cmd.data;
      if (cmd.latchHiWr) latch[CNT_W-1:BUS_W] <= cmd.data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '1;
      holdOne <= 1'b0;
    end else if (cmd.ctrlWr && cmd.forceLoad) begin
      count   <= latch;
      holdOne <= cmd.data[BIT_RUN];
    end else if (cmd.ctrlWr && cmd.stopNow) begin
      if (count != '0) count <= count - 1'b1;
      holdOne <= 1'b0;
    end else if (cmd.latchHiWr && !cmd.runBit) begin
      count <= {cmd.data, latch[BUS_W-1:0]};
    end else if (cmd.runBit && cmd.countEn) begin
      if (holdOne)            holdOne <= 1'b0;
      else if (count == '0)   count   <= latch;
      else                    count   <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      underQ  <= 1'b0;
      toggleQ <= 1'b0;
    end else begin
      underQ <= wrapNow;
      if (cmd.startNow)  toggleQ <= 1'b1;
      else if (wrapNow)  toggleQ <= ~toggleQ;
    end
  end
endmodule

// File: rtl/dualTimer.sv
module dualTimer
  import timerPkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [BUS_W-1:0]  wrData,
  output logic [BUS_W-1:0]  rdData,
  output logic [NUM_TIMERS-1:0] timerUnder,
  output logic [NUM_TIMERS-1:0] portVal,
  output logic [NUM_TIMERS-1:0] portEn
);
  timerCmd_t [NUM_TIMERS-1:0]       cmd;
  logic [NUM_TIMERS-1:0][CNT_W-1:0] countVal;
  logic [NUM_TIMERS-1:0]            expired;

  timerRegs regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .regAddr    (regAddr),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .wrData     (wrData),
    .countVal   (countVal),
    .expired    (expired),
    .chainPulse (timerUnder[NUM_TIMERS-2:0]),
    .cmd        (cmd),
    .rdData     (rdData)
  );

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : gCore
    timerCore core (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd       (cmd[t]),
      .count     (countVal[t]),
      .underQ    (timerUnder[t]),
      .expired   (expired[t]),
      .portDrive (portVal[t]),
      .portEn    (portEn[t])
    );
  end
endmodule

// File: rtl/dualTimerChecker.sv
module dualTimerChecker
  import timerPkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [BUS_W-1:0]  wrData,
  input logic              runA,
  input logic              toggleSelA,
  input logic              expiredA,
  input logic              runB,
  input logic              countEnB,
  input logic              underA,
  input logic              portA,
  input logic [CNT_W-1:0]  countA,
  input logic [CNT_W-1:0]  countB
);
  assert_oneshot_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    expiredA |=> !runA);

  assert_toggle_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(runA) && toggleSelA) |-> portA);

  assert_stopped_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!runA && !wrEn) |=> $stable(countA));

  assert_gated_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (runB && !countEnB && !wrEn) |=> $stable(countB));

  assert_pulse_running_R3: assert property (@(posedge clk) disable iff (!rst_n)
    underA |-> $past(runA));

  assert_stop_decrement_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (runA && wrEn && regAddr == ADDR_W'(CTRL_BASE) && !wrData[BIT_RUN] &&
     !wrData[BIT_LOAD] && countA != '0) |=> (countA == $past(countA) - 1'b1));
endmodule

bind dualTimer dualTimerChecker chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wrEn       (wrEn),
  .regAddr    (regAddr),
  .wrData     (wrData),
  .runA       (cmd[0].runBit),
  .toggleSelA (cmd[0].toggleSel),
  .expiredA   (expired[0]),
  .runB       (cmd[1].runBit),
  .countEnB   (cmd[1].countEn),
  .underA     (timerUnder[0]),
  .portA      (portVal[0]),
  .countA     (countVal[0]),
  .countB     (countVal[1])
);

// File: tb/dualTimer_test.sv
module dualTimer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] regAddr = '0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = '0;
  wire  [7:0] rdData;
  wire  [1:0] timerUnder;
  wire  [1:0] portVal;
  wire  [1:0] portEn;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  dualTimer uut (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .timerUnder(timerUnder),
    .portVal(portVal), .portEn(portEn)
  );

  task automatic eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input int a, input int d);
    regAddr = a[3:0];
    wrData  = d[7:0];
    wrEn    = 1'b1;
    tick();
    wrEn    = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    regAddr = a[3:0];
    rdEn    = 1'b1;
    #1;
    v       = int'(rdData);
    rdEn    = 1'b0;
  endtask

  task automatic cnt(input int t, output int v);
    int lo, hi;
    rd(2 * t, lo);
    rd(2 * t + 1, hi);
    v = hi * 256 + lo;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v, v2, c;
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;

    // R1 reset state
    cnt(0, v); eq("R1 counter A", v, 16'hFFFF);
    cnt(1, v); eq("R1 counter B", v, 16'hFFFF);
    rd(4, v);  eq("R1 ctrl A", v, 0);
    rd(5, v);  eq("R1 ctrl B", v, 0);
    eq("R1 underflow", int'(timerUnder), 0);
    eq("R1 port enable", int'(portEn), 0);

    // R2 low byte alone leaves the counter; R11 reads have no effect
    wr(0, 8'h34);
    cnt(0, v); eq("R2 low byte no load", v, 16'hFFFF);
    wr(1, 8'h12);
    cnt(0, v); eq("R2 high byte loads", v, 16'h1234);
    tick(); tick();
    cnt(0, v); cnt(0, v2);
    eq("R11 repeated read", v2, 16'h1234);
    eq("R2 stopped holds", v, 16'h1234);

    // R3 / R10 / R7 sweep over small latch values on timer A
    for (int L = 0; L < 6; L++) begin
      int cr, tog, last;
      cr = (L % 2 == 1) ? 8'h07 : 8'h03;
      wr(0, L); wr(1, 0);
      cnt(0, v); eq("R2 reload via high byte", v, L);
      wr(4, cr);
      tog = 1;
      last = L;
      for (int k = 1; k <= 3 * (L + 1) + 2; k++) begin
        int expC, expU;
        tick();
        if (k <= L) begin
          expC = L - k;
          expU = 0;
        end else begin
          expC = L - ((k - L - 1) % (L + 1));
          expU = ((k - L - 1) % (L + 1) == 0) ? 1 : 0;
        end
        if (expU == 1) tog = 1 - tog;
        cnt(0, v);
        eq("R3 count", v, expC);
        eq("R3 underflow pulse", int'(timerUnder[0]), expU);
        eq("R10 port value", int'(portVal[0]), (cr == 8'h07) ? tog : expU);
        eq("R10 port enable", int'(portEn[0]), 1);
        last = expC;
      end
      wr(4, 0);
      cnt(0, v); eq("R7 stop decrement", v, (last > 0) ? last - 1 : 0);
      tick(); tick();
      cnt(0, v2); eq("R7 holds after stop", v2, v);
    end

    // R4 one-shot
    wr(0, 3); wr(1, 0);
    wr(4, 8'h09);
    for (int k = 1; k <= 8; k++) begin
      tick();
      cnt(0, v);
      eq("R4 one-shot count", v, (k <= 3) ? 3 - k : 3);
      eq("R4 one-shot pulse", int'(timerUnder[0]), (k == 4) ? 1 : 0);
      rd(4, c);
      eq("R4 run bit cleared", c, (k < 4) ? 8'h09 : 8'h08);
    end

    // R5 / R6 force-load with start, then force-load with stop
    wr(0, 9); wr(1, 0);
    wr(0, 4);
    cnt(0, v); eq("R2 latch only", v, 9);
    wr(4, 8'h11);
    cnt(0, v); eq("R5 force-load copies latch", v, 4);
    rd(4, c);  eq("R5 strobe reads zero", c, 8'h01);
    for (int k = 1; k <= 3; k++) begin
      tick();
      cnt(0, v);
      eq("R6 delayed first decrement", v, (k == 1) ? 4 : 5 - k);
    end
    wr(4, 8'h10);
    cnt(0, v); eq("R5 force-load on stop", v, 4);
    rd(4, c);  eq("R5 strobe reads zero on stop", c, 0);

    // R11 latch write while running
    wr(0, 6); wr(1, 0);
    wr(4, 8'h01);
    tick(); tick();
    cnt(0, v); eq("R3 running count", v, 4);
    wr(0, 2);
    cnt(0, v); eq("R11 running latch write", v, 3);
    for (int k = 1; k <= 5; k++) begin
      int seqv[5] = '{2, 1, 0, 2, 1};
      tick();
      cnt(0, v);
      eq("R11 new latch at next reload", v, seqv[k-1]);
      eq("R11 pulse", int'(timerUnder[0]), (k == 4) ? 1 : 0);
    end
    wr(4, 0);

    // R8 cascade: A latch 2, B latch 1
    wr(0, 2); wr(1, 0);
    wr(2, 1); wr(3, 0);
    wr(5, 8'h41);
    tick(); tick(); tick();
    cnt(1, v); eq("R8 B idle without A pulses", v, 1);
    wr(4, 8'h01);
    for (int k = 1; k <= 20; k++) begin
      int s, expB, expU;
      tick();
      s = (k - 1) / 3;
      expB = (s == 0) ? 1 : ((s % 2 == 1) ? 0 : 1);
      expU = ((k - 1) % 3 == 0 && s >= 2 && s % 2 == 0) ? 1 : 0;
      cnt(1, v);
      eq("R8 cascade count", v, expB);
      eq("R8 cascade pulse", int'(timerUnder[1]), expU);
    end
    wr(4, 0);
    wr(5, 0);

    // R9 pin mode holds timer B
    wr(2, 5); wr(3, 0);
    wr(5, 8'h21);
    for (int k = 1; k <= 4; k++) begin
      tick();
      cnt(1, v);
      eq("R9 pin mode holds", v, 5);
      eq("R9 no pulse", int'(timerUnder[1]), 0);
    end
    wr(5, 0);
    cnt(1, v); eq("R7 stop decrement B", v, 4);
    wr(5, 8'h63);
    tick(); tick();
    cnt(1, v); eq("R9 pin with cascade holds", v, 4);
    eq("R10 port enable B", int'(portEn[1]), 1);
    eq("R10 pulse form idle", int'(portVal[1]), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule